// File: doc/BRIEF.md
# Retransmit-Capable FIFO Buffer

This block is a first-in/first-out store of 9-bit words, wide enough for eight data bits and one parity or control bit. Words go in when `wr_en` is high at a clock edge and come out when `rd_en` is high. Two internal ring pointers pick the storage locations, so the user never gives an address. A write and a read may both be asked for in the same cycle, and both are carried out when neither is blocked. The depth is a parameter and may be 256, 512 or 1024 words.

Three active-low flags report how full the buffer is: empty, half-full and full. A full buffer ignores a write and an empty buffer ignores a read. Pulling the active-low retransmit input low moves the read side back to the first location. The data written since reset can then be read out again. The reset input is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `rtfifo`

## Requirements
- R1: While reset is held and after it is released, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `rd_data` is 0. Asserting reset in mid-run discards all stored words.
- R2: Words are read out in the order they were written, with all 9 bits kept. After the clock edge of an accepted read, `rd_data` shows the oldest stored word.
- R3: `full_n` is 0 exactly when DEPTH words are held. A write while `full_n` is 0 is ignored, even when a read is accepted in the same cycle, and the word is never stored.
- R4: `empty_n` is 0 exactly when no word is held. A read while `empty_n` is 0 is ignored and leaves `rd_data` unchanged.
- R5: A write and a read in the same cycle, with neither blocked, are both carried out. The occupancy does not change. A write and a read in the same cycle on an empty buffer store the word and return nothing.
- R6: `half_n` is 0 exactly when the occupancy is greater than DEPTH/2. With DEPTH 256, it is still 1 at 128 words and is 0 at 129 words.
- R7: When `rt_n` is 0 at a clock edge, the read position returns to the first location. A read asked for in that cycle is ignored, and a write in that cycle is still accepted. Later reads replay from the first word written after reset. From the next cycle the flags reflect the number of words written since reset.
- R8: The pointers wrap at DEPTH, so FIFO order is kept across the end of the storage.
- R9: `rd_data` holds its value in every cycle that has no accepted read.
- R10: DEPTH must be 256, 512 or 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Word to write |
| rd_en | input | 1 | Read request |
| rt_n | input | 1 | Retransmit, active low; rewinds the read position |
| rd_data | output | 9 | Last word read |
| empty_n | output | 1 | Low when no word is held |
| half_n | output | 1 | Low when more than DEPTH/2 words are held |
| full_n | output | 1 | Low when DEPTH words are held |

## Verification
The occupancy is taken as the write count minus the read position. The checks therefore assume that a retransmit is only used while fewer than DEPTH words have been written since reset. The stimulus only retransmits early in a run, when just a few words have been written. Before any long fill-and-drain, it applies a reset. Inputs change only on the falling clock edge, so they are stable at every rising edge that the assertions sample.

// File: rtl/rtfifo_pkg.sv
package rtfifo_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;

  function automatic bit depth_ok(int d);
    return (d == 256) || (d == 512) || (d == 1024);
  endfunction
endpackage

// File: rtl/rtfifo_ptr_ctrl.sv
module rtfifo_ptr_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             rt_n,
  input  logic             is_full,
  input  logic             is_empty,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic [AW-1:0]    waddr,
  output logic [AW-1:0]    raddr,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] wptr_q, wptr_d;
  logic [CNT_W-1:0] rptr_q, rptr_d;
  logic             wptr_en, rptr_en;

  // Accept logic; retransmit takes priority over a read
  always_comb begin
    wr_ok   = wr_en & ~is_full;
    rd_ok   = rd_en & rt_n & ~is_empty;
    wptr_en = wr_ok;
    rptr_en = rd_ok | ~rt_n;
    wptr_d  = wptr_q + CNT_W'(1);
    rptr_d  = rt_n ? (rptr_q + CNT_W'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wptr_en) wptr_q <= wptr_d;
      if (rptr_en) rptr_q <= rptr_d;
    end
  end

  always_comb begin
    waddr = wptr_q[AW-1:0];
    raddr = rptr_q[AW-1:0];
    count = wptr_q - rptr_q;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3
  full_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_full) |=> $stable(wptr_q));

  // R7
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (rptr_q == '0));
endmodule

// File: rtl/rtfifo_store.sv
module rtfifo_store
  import rtfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic [AW-1:0] waddr,
  input  word_t         wr_data,
  input  logic          rd_ok,
  input  logic [AW-1:0] raddr,
  output word_t         rd_data
);
  word_t mem [DEPTH];
  word_t rd_data_q;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data_q <= '0;
    else if (rd_ok) rd_data_q <= mem[raddr];
  end

  assign rd_data = rd_data_q;
endmodule

// File: rtl/rtfifo_flags.sv
module rtfifo_flags #(
  parameter int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic [CNT_W-1:0] count,
  output logic             is_empty,
  output logic             is_half,
  output logic             is_full
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  always_comb begin
    is_empty = (count == '0);
    is_full  = (count == FULL_CNT);
    is_half  = (count > HALF_CNT);
  end
endmodule

// File: rtl/rtfifo.sv
module rtfifo
  import rtfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rt_n,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty_n,
  output logic              half_n,
  output logic              full_n
);
  logic             rst_meta, rst_sync;
  logic             wr_ok, rd_ok, is_empty, is_half, is_full;
  logic [AW-1:0]    waddr, raddr;
  logic [CNT_W-1:0] count;

  initial begin
    // R10
    depth_legal_chk: assert (depth_ok(DEPTH)) else $error("illegal DEPTH %0d", DEPTH);
  end

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  rtfifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .rd_en(rd_en), .rt_n(rt_n),
    .is_full(is_full), .is_empty(is_empty), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .waddr(waddr), .raddr(raddr), .count(count)
  );

  rtfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_sync), .wr_ok(wr_ok), .waddr(waddr), .wr_data(wr_data),
    .rd_ok(rd_ok), .raddr(raddr), .rd_data(rd_data)
  );

  rtfifo_flags #(.DEPTH(DEPTH)) u_flags (
    .count(count), .is_empty(is_empty), .is_half(is_half), .is_full(is_full)
  );

  assign empty_n = ~is_empty;
  assign half_n  = ~is_half;
  assign full_n  = ~is_full;

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (!rd_en || !empty_n || !rt_n) |=> $stable(rd_data));

  // R3
  full_stays_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (!full_n && wr_en && !rd_en && rt_n) |=> !full_n);

  // R4
  empty_stays_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (!empty_n && rd_en && !wr_en && rt_n) |=> !empty_n);

  // R6
  half_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !half_n |-> empty_n);
endmodule

// File: tb/rtfifo_bench.sv
module rtfifo_bench;
  localparam int DEPTH = 256;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic       rt_n;
    logic [8:0] din;
    logic [8:0] dout;
    logic       e_n;
    logic       f_n;
    logic       h_n;
  } vec_t;

  // Expected values after each step, starting from an empty buffer
  localparam vec_t TBL [13] = '{
    '{1'b1, 1'b0, 1'b1, 9'h101, 9'h000, 1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b1, 9'h0AA, 9'h000, 1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b1, 9'h155, 9'h000, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 9'h000, 9'h101, 1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b1, 9'h1FF, 9'h0AA, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 9'h000, 9'h155, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 9'h000, 9'h1FF, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 9'h000, 9'h1FF, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 9'h000, 9'h1FF, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 9'h000, 9'h101, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 9'h000, 9'h0AA, 1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b0, 9'h033, 9'h0AA, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 9'h000, 9'h101, 1'b1, 1'b1, 1'b1}
  };

  logic       clk, rst_n, wr_en, rd_en, rt_n;
  logic [8:0] wr_data, rd_data;
  logic       empty_n, half_n, full_n;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  rtfifo #(.DEPTH(DEPTH)) u_rtfifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rt_n(rt_n), .rd_data(rd_data), .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, check 5 ns after the rising edge, then go idle
  task automatic step(logic w, logic r, logic t, logic [8:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; rt_n = t; wr_data = d;
    @(posedge clk);
    #5;
    wr_en = 1'b0; rd_en = 1'b0; rt_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 async reset", {rd_data, empty_n, full_n, half_n}, {9'h000, 3'b011});
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [8:0] pat(int i);
    return 9'((i * 7 + 3) & 9'h1FF);
  endfunction

  initial begin
    bit bad;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rt_n = 1'b1; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", {rd_data, empty_n, full_n, half_n}, {9'h000, 3'b011});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 flags after reset", {rd_data, empty_n, full_n, half_n}, {9'h000, 3'b011});

    // Vector table: order (R2), simultaneous (R5), empty (R4), retransmit (R7), hold (R9)
    foreach (TBL[k]) begin
      step(TBL[k].wr, TBL[k].rd, TBL[k].rt_n, TBL[k].din);
      chk($sformatf("R2 R4 R5 R7 R9 vector %0d", k),
          {rd_data, empty_n, full_n, half_n},
          {TBL[k].dout, TBL[k].e_n, TBL[k].f_n, TBL[k].h_n});
    end

    // Mid-run reset drops stored words (R1)
    do_reset();
    step(1'b0, 1'b1, 1'b1, 9'h000);
    chk("R1 reset discards words", {rd_data, empty_n}, {9'h000, 1'b0});

    // Fill to full, watching half-full (R6) and full (R3)
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, 1'b1, pat(i));
      if (i + 1 == DEPTH / 2)     chk("R6 half_n at DEPTH/2", 12'(half_n), 12'd1);
      if (i + 1 == DEPTH / 2 + 1) chk("R6 half_n above DEPTH/2", 12'(half_n), 12'd0);
      if (i + 1 == DEPTH - 1)     chk("R3 full_n one short", 12'(full_n), 12'd1);
    end
    chk("R3 full_n at DEPTH", {empty_n, full_n, half_n}, 12'b100);

    step(1'b1, 1'b0, 1'b1, 9'h1EE);
    chk("R3 write while full ignored", {rd_data, full_n}, {9'h000, 1'b0});

    step(1'b1, 1'b1, 1'b1, 9'h1EE);
    chk("R3 read accepted, write blocked when full", {rd_data, full_n}, {pat(0), 1'b1});

    // Drain the rest; the blocked words must not appear (R2, R3)
    bad = 0;
    for (int i = 1; i < DEPTH; i++) begin
      step(1'b0, 1'b1, 1'b1, 9'h000);
      if (rd_data !== pat(i)) begin
        bad = 1;
        $display("FAIL R2 drain word %0d: actual %h expected %h", i, rd_data, pat(i));
      end
    end
    chk("R2 drain order", 12'(bad), 12'd0);
    chk("R4 empty after drain", {empty_n, full_n, half_n}, 12'b011);

    // Write and read together while empty (R5), across the pointer wrap (R8)
    step(1'b1, 1'b1, 1'b1, 9'h0C3);
    chk("R5 simultaneous on empty", {rd_data, empty_n}, {pat(DEPTH - 1), 1'b1});
    step(1'b0, 1'b0, 1'b1, 9'h000);
    chk("R9 idle holds output", 12'(rd_data), 12'(pat(DEPTH - 1)));
    step(1'b0, 1'b1, 1'b1, 9'h000);
    chk("R8 word after wrap", {rd_data, empty_n}, {9'h0C3, 1'b0});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule